// File: doc/BRIEF.md
# System Exception Pending Arbiter

This block holds the pending state of four core system exceptions: the non-maskable interrupt (number 2), the hard fault (number 3), the supervisor call (number 11) and the deferred service request (number 14). Each cycle it presents the most urgent pending one to the CPU core. With it goes a selector that says where the handler address must be fetched from: the flash vector table, the RAM vector table or the boot ROM.

Software reaches the block through a small write port with four word addresses: a pending control word, two priority words and a vector-table select word. Hardware pulses mark an executed SVC instruction, a fault and a system-call request. The core pulses `ack` for one cycle when it takes the presented exception, and that clears the exception's pending flag. All pending state is registered, so any stimulus shows at the outputs one clock edge later.

Top module: `sysexc_arbiter`

## Requirements
- R1: After reset no exception is pending, `req_valid` is 0, `exc_num` is 0, `svc_pending` is 0, both programmable priorities are 0 and the flash table is selected (`vec_src` = 0). Whenever nothing is pending, `exc_num` reads 0.
- R2: The non-maskable interrupt (number 2) becomes pending when bit 0 of a write to address 0 is 1, or when `sysreq_evt` pulses. While it is pending it is always the one presented.
- R3: A `fault_evt` pulse makes the hard fault (number 3) pending. It outranks both programmable exceptions and loses only to the non-maskable interrupt.
- R4: The supervisor-call priority is bits [31:30] of a write to address 1. The deferred-service priority is bits [23:22] of a write to address 2. Other bits of those writes are ignored, and of two pending programmable exceptions the one with the lower value wins.
- R5: When the two programmable priorities are equal, the supervisor call (11) beats the deferred service request (14).
- R6: An `svc_evt` pulse, or bit 3 of a write to address 0, makes the supervisor call pending. Bit 4 of a write to address 0 clears it, and `svc_pending` shows its flag.
- R7: Bit 1 of a write to address 0 makes the deferred service request pending, and bit 2 of such a write clears it.
- R8: When a set and a clear (by write bit or by `ack`) reach the same flag in one cycle, the flag ends up set.
- R9: `vec_src` is 2 (boot ROM) while a non-maskable interrupt raised by `sysreq_evt` is pending, including when a software set arrived in the same cycle. Otherwise it is the table select, bit 0 of a write to address 3 (0 = flash, 1 = RAM).
- R10: An `ack` pulse clears the pending flag of the exception presented in that cycle. An `ack` while nothing is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 pending control, 1 supervisor-call priority, 2 deferred-service priority, 3 table select |
| wr_data | input | 32 | Write data |
| svc_evt | input | 1 | SVC instruction executed |
| fault_evt | input | 1 | Fault detected |
| sysreq_evt | input | 1 | System-call request |
| ack | input | 1 | Core takes the presented exception |
| req_valid | output | 1 | Some exception is pending |
| exc_num | output | 4 | Number of the winning exception |
| vec_src | output | 2 | Handler source: 0 flash, 1 RAM, 2 boot ROM |
| svc_pending | output | 1 | Supervisor-call pending flag |

## Verification
A flag that is wrongly set or wrongly cleared shows at `exc_num` and `req_valid` on the cycle after the event that disturbed it. The exception is when a higher-ranked flag is pending at the same time and masks it. The bench therefore drains the pending set one `ack` at a time, so that each lower flag in turn reaches the outputs. A lost boot-ROM marker shows as `vec_src` falling back to the table select while number 2 is still presented. Equal and reversed priority values are both driven, so that a wrong tie-break or a swapped comparison changes the winner within one cycle.

// File: rtl/sysexc_arbiter.sv
module sysexc_arbiter #(
  parameter int NUM_W = 4,
  parameter int PRI_W = 2,
  parameter int SVC_PRI_LSB = 30,
  parameter int PSV_PRI_LSB = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             svc_evt,
  input  logic             fault_evt,
  input  logic             sysreq_evt,
  input  logic             ack,
  output logic             req_valid,
  output logic [NUM_W-1:0] exc_num,
  output logic [1:0]       vec_src,
  output logic             svc_pending
);

  localparam logic [NUM_W-1:0] N_NONE = NUM_W'(0);
  localparam logic [NUM_W-1:0] N_NMI  = NUM_W'(2);
  localparam logic [NUM_W-1:0] N_HF   = NUM_W'(3);
  localparam logic [NUM_W-1:0] N_SVC  = NUM_W'(11);
  localparam logic [NUM_W-1:0] N_PSV  = NUM_W'(14);
  localparam logic [1:0] SRC_ROM = 2'd2;

  logic nmi_p, nmi_rom, hf_p, svc_p, psv_p, tbl_ram;
  logic [PRI_W-1:0] svc_pri, psv_pri;

  wire wr_ctl = wr_en && (wr_addr == 2'd0);
  wire wr_svp = wr_en && (wr_addr == 2'd1);
  wire wr_psp = wr_en && (wr_addr == 2'd2);
  wire wr_tbl = wr_en && (wr_addr == 2'd3);

  wire nmi_set = (wr_ctl && wr_data[0]) || sysreq_evt;
  wire psv_set = wr_ctl && wr_data[1];
  wire psv_clr = wr_ctl && wr_data[2];
  wire svc_set = (wr_ctl && wr_data[3]) || svc_evt;
  wire svc_clr = wr_ctl && wr_data[4];

  wire svc_wins = svc_p && (!psv_p || (svc_pri <= psv_pri));

  always_comb begin
    if (nmi_p)         exc_num = N_NMI;
    else if (hf_p)     exc_num = N_HF;
    else if (svc_wins) exc_num = N_SVC;
    else if (psv_p)    exc_num = N_PSV;
    else               exc_num = N_NONE;
  end

  assign req_valid   = nmi_p | hf_p | svc_p | psv_p;
  assign vec_src     = (nmi_p && nmi_rom) ? SRC_ROM : {1'b0, tbl_ram};
  assign svc_pending = svc_p;

  wire ack_nmi = ack && (exc_num == N_NMI);
  wire ack_hf  = ack && (exc_num == N_HF);
  wire ack_svc = ack && (exc_num == N_SVC);
  wire ack_psv = ack && (exc_num == N_PSV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_p   <= 1'b0;
      nmi_rom <= 1'b0;
      hf_p    <= 1'b0;
      svc_p   <= 1'b0;
      psv_p   <= 1'b0;
      tbl_ram <= 1'b0;
      svc_pri <= '0;
      psv_pri <= '0;
    end else begin
      nmi_p   <= nmi_set    || (nmi_p && !ack_nmi);
      nmi_rom <= sysreq_evt || (nmi_rom && !ack_nmi);
      hf_p    <= fault_evt  || (hf_p && !ack_hf);
      svc_p   <= svc_set    || (svc_p && !svc_clr && !ack_svc);
      psv_p   <= psv_set    || (psv_p && !psv_clr && !ack_psv);
      if (wr_tbl) tbl_ram <= wr_data[0];
      if (wr_svp) svc_pri <= wr_data[SVC_PRI_LSB +: PRI_W];
      if (wr_psp) psv_pri <= wr_data[PSV_PRI_LSB +: PRI_W];
    end
  end

  a_r2_nmi_presented: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_set |=> (req_valid && exc_num == N_NMI));

  a_r9_sysreq_rom: assert property (@(posedge clk) disable iff (!rst_n)
    sysreq_evt |=> (vec_src == SRC_ROM));

  a_r3_fault_rank: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && !nmi_p && !nmi_set) |=> (exc_num == N_HF));

  a_r6_svc_event: assert property (@(posedge clk) disable iff (!rst_n)
    svc_evt |=> svc_pending);

  a_r8_set_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (psv_set && psv_clr) |=> req_valid);

  a_r10_ack_drops_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && exc_num == N_HF && !fault_evt && !nmi_set) |=> (exc_num != N_HF));

  a_r1_idle_number: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (exc_num == N_NONE));

endmodule

// File: tb/sysexc_arbiter_test.sv
module sysexc_arbiter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, svc_evt = 1'b0, fault_evt = 1'b0, sysreq_evt = 1'b0, ack = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic req_valid, svc_pending;
  logic [3:0] exc_num;
  logic [1:0] vec_src;

  typedef struct packed {
    logic       v;
    logic [3:0] n;
    logic [1:0] s;
    logic       sp;
    logic [7:0] req;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sysexc_arbiter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .svc_evt(svc_evt), .fault_evt(fault_evt), .sysreq_evt(sysreq_evt), .ack(ack),
    .req_valid(req_valid), .exc_num(exc_num), .vec_src(vec_src), .svc_pending(svc_pending)
  );

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      nchk++;
      if ({req_valid, exc_num, vec_src, svc_pending} != {e.v, e.n, e.s, e.sp}) begin
        nfail++;
        $display("FAIL R%0d: actual v=%0b n=%0d src=%0d sp=%0b expected v=%0b n=%0d src=%0d sp=%0b",
                 e.req, req_valid, exc_num, vec_src, svc_pending, e.v, e.n, e.s, e.sp);
      end
    end
  end

  task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                     input logic sv, input logic fl, input logic sr, input logic ak,
                     input logic ev, input logic [3:0] en, input logic [1:0] es,
                     input logic esp, input int rq);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    svc_evt = sv; fault_evt = fl; sysreq_evt = sr; ack = ak;
    e.v = ev; e.n = en; e.s = es; e.sp = esp; e.req = 8'(rq);
    q.push_back(e);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL R1: watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nchk++;  // R1 reset state at the ports
    if ({req_valid, exc_num, vec_src, svc_pending} != 8'd0) begin
      nfail++;
      $display("FAIL R1: actual %0h expected 0", {req_valid, exc_num, vec_src, svc_pending});
    end
    cyc(0,0,0, 0,0,0,0, 0,0,0,0, 1);               // R1 idle
    cyc(0,0,0, 0,0,0,1, 0,0,0,0, 10);              // R10 ack with nothing pending
    cyc(1,2,32'h0040_0000, 0,0,0,0, 0,0,0,0, 4);   // R4 deferred prio 1
    cyc(1,0,32'h2, 0,0,0,0, 1,14,0,0, 7);          // R7 set deferred
    cyc(0,0,0, 1,0,0,0, 1,11,0,1, 6);              // R6 svc event, prio 0 beats 1
    cyc(1,1,32'h8000_0000, 0,0,0,0, 1,14,0,1, 4);  // R4 svc prio 2 loses to 1
    cyc(1,2,32'h0080_0000, 0,0,0,0, 1,11,0,1, 5);  // R5 tie -> 11
    cyc(1,3,32'h1, 0,0,0,0, 1,11,1,1, 9);          // R9 RAM table
    cyc(0,0,0, 0,1,0,0, 1,3,1,1, 3);               // R3 fault outranks
    cyc(1,0,32'h1, 0,0,0,0, 1,2,1,1, 2);           // R2 software NMI, active table
    cyc(0,0,0, 0,0,1,0, 1,2,2,1, 9);               // R9 system call -> ROM
    cyc(0,0,0, 0,0,0,1, 1,3,1,1, 10);              // R10 ack NMI
    cyc(0,0,0, 0,0,0,1, 1,11,1,1, 10);             // R10 ack fault
    cyc(0,0,0, 1,0,0,1, 1,11,1,1, 8);              // R8 ack + svc event -> set
    cyc(1,0,32'h10, 0,0,0,0, 1,14,1,0, 6);         // R6 svc clear
    cyc(1,0,32'h6, 0,0,0,0, 1,14,1,0, 8);          // R8 set+clr deferred -> set
    cyc(1,0,32'h4, 0,0,0,0, 0,0,1,0, 7);           // R7 clear deferred
    cyc(1,0,32'h1, 0,0,1,0, 1,2,2,0, 9);           // R9 both NMI sources -> ROM
    cyc(0,0,0, 0,0,0,1, 0,0,1,0, 10);              // R10 ack
    cyc(1,0,32'h1, 0,0,0,0, 1,2,1,0, 9);           // R9 software NMI, RAM
    cyc(0,0,0, 0,0,0,1, 0,0,1,0, 10);              // R10 ack
    cyc(1,3,32'h0, 0,0,0,0, 0,0,0,0, 9);           // R9 back to flash
    cyc(1,0,32'h8, 0,0,0,0, 1,11,0,1, 6);          // R6 svc set by write
    cyc(1,1,32'h3FFF_FFFF, 0,0,0,0, 1,11,0,1, 4);  // R4 svc prio 0, low bits ignored
    cyc(1,2,32'hFF3F_FFFF, 0,0,0,0, 1,11,0,1, 4);  // R4 deferred prio 0, other bits ignored
    cyc(1,0,32'h2, 0,0,0,0, 1,11,0,1, 5);          // R5 tie 0/0 -> 11
    cyc(0,0,0, 0,0,0,1, 1,14,0,0, 10);             // R10 ack svc
    cyc(1,1,32'h4000_0000, 0,0,0,0, 1,14,0,0, 4);  // R4 svc prio 1
    cyc(0,0,0, 1,0,0,0, 1,14,0,1, 4);              // R4 svc 1 loses to deferred 0
    cyc(0,0,0, 0,0,0,1, 1,11,0,1, 10);             // R10 ack deferred
    cyc(0,0,0, 0,0,0,1, 0,0,0,0, 10);              // R10 ack svc
    cyc(0,0,0, 0,0,0,0, 0,0,0,0, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end
endmodule